// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Responder

This block sits on the device side of a processor's maskable interrupt input. It gathers up to eight active-low request lines into one active-high interrupt request. It answers the processor's two-pulse acknowledge handshake by putting an 8-bit vector type number on the data bus. A tri-state enable marks the one window in which the bus may be driven.

The vector is built from a base value. Starting from that base, every bit whose request line is pending is forced to zero, so each combination of simultaneous requests gives its own vector. With a base of FFH and no request, the vector is FFH. With a base of 80H and no request, the vector is 80H.

A mode input chooses how requests are seen:
- In level mode, a line is pending while it is held low.
- In edge mode, a falling edge on a line sets a latch. The latches are cleared when the first acknowledge pulse begins.

Request lines pass through a two-flop synchronizer. The acknowledge strobe is taken as synchronous to the clock.

Top module: `irq_vector_responder`

## Requirements
- R1: While reset is asserted, and on the first clock edges after it is released, `intr_o`, `vec_oe_o` and `vec_o` are all 0, and no request latch is set.
- R2: In level mode (`edge_mode_i`=0), `intr_o` is 1 whenever at least one request line is 0, and 0 when all lines are 1. It follows a line change within three clock edges.
- R3: In level mode, an acknowledge sequence does not lower `intr_o` while a request line stays low.
- R4: In edge mode (`edge_mode_i`=1), a 1-to-0 transition on request line i sets a latch that keeps `intr_o` at 1 after the line returns to 1.
- R5: In edge mode, every latch is cleared at the clock edge where the first acknowledge pulse is first seen low. An edge that arrives later, during the sequence, stays pending for the next sequence.
- R6: The vector equals `vec_base_i` with bit i forced to 0 for each pending request line i (bit 0 belongs to line 0). It is captured at the edge where the first acknowledge pulse is first seen low.
- R7: The captured vector does not change until the second acknowledge pulse ends, even if request lines or `vec_base_i` change in the meantime.
- R8: `vec_oe_o` is 1 only during the second acknowledge pulse. It rises one edge after `inta_ni` is sampled low for that pulse, and falls one edge after `inta_ni` is sampled high again. It is 0 during the first pulse and during the gap between the pulses.
- R9: Whenever `vec_oe_o` is 0, `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| edge_mode_i | input | 1 | 1 = requests latched on falling edges, 0 = level-sensitive requests |
| req_ni | input | 8 | Active-low request lines; bit i maps to vector bit i |
| inta_ni | input | 1 | Active-low acknowledge strobe, two pulses per acknowledge |
| vec_base_i | input | 8 | Base vector value before request bits are cleared |
| intr_o | output | 1 | Active-high interrupt request to the processor |
| vec_o | output | 8 | Vector type number; zero when not enabled |
| vec_oe_o | output | 1 | Data bus drive enable for the vector |

## Verification
Each internal fault shows up at the ports in a specific way and at a specific time:
- A latch that stays stuck set or stuck clear in edge mode shows on `intr_o` within three edges of the line change. It also shows as a wrong bit in the next vector.
- A broken acknowledge sequencer enables the bus in the wrong pulse. This is visible one edge after `inta_ni` changes.
- A vector register that keeps loading during the sequence shows as a changed `vec_o` while the enable is high. The bench moves the request lines in the gap between the pulses to expose exactly this fault.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE  = 2'd0,
    ACK_FIRST = 2'd1,
    ACK_GAP   = 2'd2,
    ACK_SECOND = 2'd3
  } ack_state_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/irq_req_capture.sv
module irq_req_capture #(
  parameter int NUM_REQ = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_mode_i,
  input  logic [NUM_REQ-1:0] req_ni,
  input  logic               clr_i,
  output logic [NUM_REQ-1:0] pend_o
);
  logic [NUM_REQ-1:0] sync_q [SYNC_STAGES];
  logic [NUM_REQ-1:0] act_s;
  logic [NUM_REQ-1:0] prev_q;
  logic [NUM_REQ-1:0] rise;
  logic [NUM_REQ-1:0] lat_q;
  logic [NUM_REQ-1:0] lat_d;

  // active-high synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= '0;
        else if (s == 0) sync_q[s] <= ~req_ni;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign act_s = sync_q[SYNC_STAGES-1];
  assign rise  = act_s & ~prev_q;

  generate
    for (genvar i = 0; i < NUM_REQ; i++) begin : g_lat
      always_comb begin
        if (!edge_mode_i) lat_d[i] = 1'b0;
        else              lat_d[i] = (lat_q[i] & ~clr_i) | rise[i];
      end

      // R5: clear at the first acknowledge wins unless a new edge lands
      a_r5_clear_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && clr_i && !rise[i]) |=> !lat_q[i]);
      // R4: a latched request survives until acknowledged
      a_r4_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (edge_mode_i && lat_q[i] && !clr_i) |=> (lat_q[i] || !edge_mode_i));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= act_s;
      lat_q  <= lat_d;
    end
  end

  assign pend_o = edge_mode_i ? lat_q : act_s;
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_vec_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inta_ni,
  input  logic [VEC_W-1:0] vec_next_i,
  output logic             ack_start_o,
  output logic             vec_oe_o,
  output logic [VEC_W-1:0] vec_o
);
  ack_state_e       state_q, state_d;
  logic [VEC_W-1:0] cap_q, cap_d;
  logic             cap_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ACK_IDLE:   if (!inta_ni) state_d = ACK_FIRST;
      ACK_FIRST:  if (inta_ni)  state_d = ACK_GAP;
      ACK_GAP:    if (!inta_ni) state_d = ACK_SECOND;
      ACK_SECOND: if (inta_ni)  state_d = ACK_IDLE;
      default:                  state_d = ACK_IDLE;
    endcase
  end

  assign cap_en      = (state_q == ACK_IDLE) && !inta_ni;
  assign ack_start_o = cap_en;
  assign cap_d       = cap_en ? vec_next_i : cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ACK_IDLE;
      cap_q   <= '0;
    end else begin
      state_q <= state_d;
      cap_q   <= cap_d;
    end
  end

  assign vec_oe_o = (state_q == ACK_SECOND);
  assign vec_o    = vec_oe_o ? cap_q : '0;

  // R8: enable rises only after a low strobe, falls only after a high one
  a_r8_oe_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_oe_o) |-> $past(!inta_ni));
  a_r8_oe_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vec_oe_o) |-> $past(inta_ni));
  // R7: vector steady while driven
  a_r7_vec_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_oe_o && $past(vec_oe_o)) |-> $stable(vec_o));
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder #(
  parameter int NUM_REQ = 8,
  parameter int VEC_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               edge_mode_i,
  input  logic [NUM_REQ-1:0] req_ni,
  input  logic               inta_ni,
  input  logic [VEC_W-1:0]   vec_base_i,
  output logic               intr_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic               vec_oe_o
);
  logic               rst_sn;
  logic [NUM_REQ-1:0] pend;
  logic [VEC_W-1:0]   pend_ext;
  logic [VEC_W-1:0]   vec_next;
  logic               ack_start;

  irq_rst_sync u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sn)
  );

  irq_req_capture #(.NUM_REQ(NUM_REQ), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .edge_mode_i(edge_mode_i),
    .req_ni     (req_ni),
    .clr_i      (ack_start),
    .pend_o     (pend)
  );

  always_comb begin
    pend_ext = '0;
    pend_ext[NUM_REQ-1:0] = pend;
  end

  assign vec_next = vec_base_i & ~pend_ext;
  assign intr_o   = |pend;

  irq_ack_seq #(.VEC_W(VEC_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sn),
    .inta_ni    (inta_ni),
    .vec_next_i (vec_next),
    .ack_start_o(ack_start),
    .vec_oe_o   (vec_oe_o),
    .vec_o      (vec_o)
  );

  // R9: bus value is zero whenever the enable is low
  a_r9_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_sn)
    !vec_oe_o |=> (vec_oe_o || vec_o == '0));
endmodule

// File: tb/irq_vector_responder_tb_top.sv
module irq_vector_responder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       edge_mode;
  logic [7:0] req_n;
  logic       inta_n;
  logic [7:0] base;
  logic       intr;
  logic [7:0] vec;
  logic       oe;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_lat;
  bit done = 0;

  always #10 clk = ~clk;

  irq_vector_responder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .edge_mode_i(edge_mode), .req_ni(req_n),
    .inta_ni(inta_n), .vec_base_i(base), .intr_o(intr), .vec_o(vec), .vec_oe_o(oe)
  );

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input logic [7:0] p);
    return b & ~p;
  endfunction

  function automatic logic [7:0] exp_pend();
    return edge_mode ? exp_lat : ~req_n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_req(input logic [7:0] v);
    if (edge_mode) exp_lat = exp_lat | (req_n & ~v);
    req_n = v;
    cyc(4);
  endtask

  task automatic set_mode(input logic m);
    req_n = 8'hFF;
    cyc(4);
    edge_mode = m;
    exp_lat = '0;
    cyc(2);
  endtask

  // full acknowledge; gap_req changes lines between pulses
  task automatic do_ack(input logic [7:0] b, input logic [7:0] gap_req);
    logic [7:0] want;
    want = exp_vec(b, exp_pend());
    base = b;
    inta_n = 1'b0;
    if (edge_mode) exp_lat = '0;
    cyc(2);
    chk("R8 oe low in first pulse", oe, 0);
    chk("R9 bus zero in first pulse", vec, 0);
    inta_n = 1'b1;
    cyc(1);
    if (edge_mode) exp_lat = exp_lat | (req_n & ~gap_req);
    req_n = gap_req;
    base = ~b;
    cyc(4);
    chk("R8 oe low in gap", oe, 0);
    inta_n = 1'b0;
    cyc(1);
    chk("R8 oe high in second pulse", oe, 1);
    chk("R6 vector value", vec, want);
    cyc(2);
    chk("R7 vector held", vec, want);
    inta_n = 1'b1;
    cyc(1);
    chk("R8 oe low after second pulse", oe, 0);
    chk("R9 bus zero after", vec, 0);
    base = b;
    cyc(1);
  endtask

  initial begin
    rst_n = 1'b0; edge_mode = 1'b0; req_n = 8'hFF; inta_n = 1'b1; base = 8'hFF;
    exp_lat = '0;
    cyc(3);
    chk("R1 intr in reset", intr, 0);
    chk("R1 oe in reset", oe, 0);
    chk("R1 vec in reset", vec, 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 intr after reset", intr, 0);
    chk("R1 oe after reset", oe, 0);

    // directed: fixed FFH and 80H with no request
    do_ack(8'hFF, 8'hFF);
    do_ack(8'h80, 8'hFF);

    // R2 level mode
    set_req(8'hFE);
    chk("R2 level intr one line", intr, 1);
    set_req(8'hFF);
    chk("R2 level intr none", intr, 0);
    set_req(8'h5A);
    chk("R2 level intr several", intr, 1);
    // R3 ack does not lower level request
    do_ack(8'hFF, 8'h5A);
    chk("R3 level intr after ack", intr, 1);

    // R4 edge mode
    set_mode(1'b1);
    set_req(8'hF7);
    set_req(8'hFF);
    chk("R4 edge latch holds", intr, 1);
    // R5 clear at first pulse, with a new edge in the gap
    do_ack(8'hFF, 8'hBF);
    chk("R5 new edge pending", intr, 1);
    set_req(8'hFF);
    do_ack(8'hFF, 8'hFF);
    chk("R5 latches cleared", intr, 0);

    // constrained random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 60; k++) begin
      logic [7:0] r;
      if ((k % 15) == 0) set_mode($urandom_range(0, 1));
      r = 8'($urandom);
      set_req(r);
      chk("R2 R4 intr", intr, |exp_pend());
      if ($urandom_range(0, 1)) set_req(8'($urandom));
      do_ack(8'($urandom), 8'($urandom));
      chk("R5 intr after ack", intr, |exp_pend());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule